// File: doc/BRIEF.md
# Host-Clocked FSK Word Unloader

The block sits behind an FSK bit recovery stage. That stage hands over one finished asynchronous word at a time. A word is framed by a start bit, carries eight data bits sent least significant bit first, and ends with a stop bit. The upstream stage presents the eight data bits and the stop bit with a one-cycle strobe. The unloader stores them and pulls an active-low ready line to tell a host that a byte is waiting.

The host then unloads the word at its own pace. It toggles a data clock input that is asynchronous to the block and reads the serial data output. Bit b0 already appears on the output when ready falls. The first host clock pulse keeps b0 on the output and releases the ready line. Each later pulse steps to the next bit, and the ninth pulse shows the received stop bit so the host can check framing. A host that does not check framing stops after eight pulses. If the host gives no clock, the ready line goes back high on its own after half a nominal bit time. That time is a parameter in system clocks, about 833 µs / 2. A word that arrives before the host has taken all eight data bits replaces the stored word and sets a sticky overrun flag.

Top module: `fsk_word_unloader`

## Requirements
- R1: After reset, rdy_n is 1, sdata is 1 and overrun is 0.
- R2: In the cycle after word_valid is sampled high, rdy_n is 0 and sdata equals word_data[0].
- R3: A qualified rising edge of host_clk is one that is seen after two synchronising flops and does not coincide with a load. Such an edge drives rdy_n high while it is low. The first qualified edge after a load keeps b0 on sdata.
- R4: Without any qualified edge, rdy_n stays 0 for exactly HALF_BIT system clock cycles after a load and then returns to 1.
- R5: Qualified edge number n after a load, for n from 1 to 8, shows data bit n-1 on sdata. Edges after the ready timeout still shift.
- R6: Qualified edge number 9 shows the stored stop bit on sdata, where 0 means a framing error. Edge number 10 returns sdata to 1 and ends the word.
- R7: A host_clk rising edge that is detected in the same cycle as a load does not count as a pulse.
- R8: word_valid arriving after fewer than 8 pulses of a loaded word sets overrun, which stays 1 until reset. The new word replaces the old one and its count restarts. A load after 8 or more pulses leaves overrun unchanged.
- R9: If host_clk is already high when a word loads, nothing shifts until host_clk goes low and rises again.
- R10: host_clk pulses while no word is held leave sdata at 1 and rdy_n at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | One-cycle strobe: a finished word is present |
| word_data | input | 8 | Received data bits, b0 in bit 0 |
| word_stop | input | 1 | Received stop bit level |
| host_clk | input | 1 | Host data clock, asynchronous |
| rdy_n | output | 1 | Byte waiting, active low |
| sdata | output | 1 | Serial data toward the host |
| overrun | output | 1 | Sticky: a word was replaced before it was unloaded |

## Verification
The hardest case to reach is a host clock rising edge that leaves the synchroniser in exactly the same system cycle as the load strobe. Hitting it needs an offset in the stimulus that matches the two-flop latency. The bench raises host_clk and asserts word_valid two cycles later so that the two coincide. It then checks that the next real pulse still shows b0 and not b1. A second hard case is a host clock held high across the ready fall. The bench drives it that way and shows that only the following fresh edge shifts.

// File: rtl/fsku_pkg.sv
`timescale 1ns/1ps
package fsku_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    typedef struct packed {
        logic              stop;
        logic [DATA_W-1:0] data;
    } frame_t;

    // Bit presented after n host pulses: pulse 0 and 1 both show b0,
    // pulse k shows frame bit k-1, beyond the stop bit the line idles high.
    function automatic logic frame_bit(input frame_t f, input logic [CNT_W-1:0] n);
        logic [FRAME_W-1:0] v;
        v = f;
        if (n == '0)
            return v[0];
        else if (n <= CNT_W'(FRAME_W))
            return v[n - 1'b1];
        else
            return 1'b1;
    endfunction

endpackage

// File: rtl/fsku_edge.sv
`timescale 1ns/1ps
module fsku_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= 1'b0;
                else if (i == 0)
                    chain[i] <= async_in;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i - 1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/fsku_ready.sv
`timescale 1ns/1ps
module fsku_ready #(
    parameter int HALF_BIT = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ack,
    output logic rdy_n
);
    localparam int CW = $clog2(HALF_BIT + 1);

    logic [CW-1:0] remain;
    logic          low;

    always_ff @(posedge clk) begin
        if (rst) begin
            low    <= 1'b0;
            remain <= '0;
        end else if (start) begin
            low    <= 1'b1;
            remain <= CW'(HALF_BIT - 1);
        end else if (low) begin
            if (ack || remain == '0)
                low <= 1'b0;
            else
                remain <= remain - 1'b1;
        end
    end

    assign rdy_n = ~low;
endmodule

// File: rtl/fsku_frame.sv
`timescale 1ns/1ps
module fsku_frame
    import fsku_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame_in,
    input  logic   shift,
    output logic   sdata,
    output logic   busy
);
    frame_t           held;
    logic [CNT_W-1:0] pulses;
    logic             loaded;

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= '0;
            pulses <= '0;
            loaded <= 1'b0;
        end else if (load) begin
            held   <= frame_in;
            pulses <= '0;
            loaded <= 1'b1;
        end else if (shift && loaded) begin
            if (pulses == CNT_W'(FRAME_W)) begin
                pulses <= '0;
                loaded <= 1'b0;
            end else begin
                pulses <= pulses + 1'b1;
            end
        end
    end

    assign sdata = loaded ? frame_bit(held, pulses) : 1'b1;
    assign busy  = loaded && (pulses < CNT_W'(DATA_W));
endmodule

// File: rtl/fsk_word_unloader.sv
`timescale 1ns/1ps
module fsk_word_unloader
    import fsku_pkg::*;
#(
    parameter int HALF_BIT    = 20000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_stop,
    input  logic              host_clk,
    output logic              rdy_n,
    output logic              sdata,
    output logic              overrun
);
    logic   rise;
    logic   shift;
    logic   busy;
    frame_t incoming;

    assign incoming.data = word_data;
    assign incoming.stop = word_stop;

    fsku_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .async_in(host_clk),
        .rise    (rise)
    );

    // An edge in the load cycle is discarded.
    assign shift = rise && !word_valid;

    fsku_ready #(.HALF_BIT(HALF_BIT)) u_ready (
        .clk  (clk),
        .rst  (rst),
        .start(word_valid),
        .ack  (shift),
        .rdy_n(rdy_n)
    );

    fsku_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .load    (word_valid),
        .frame_in(incoming),
        .shift   (shift),
        .sdata   (sdata),
        .busy    (busy)
    );

    always_ff @(posedge clk) begin
        if (rst)
            overrun <= 1'b0;
        else if (word_valid && busy)
            overrun <= 1'b1;
    end
endmodule

// File: rtl/fsku_checker.sv
`timescale 1ns/1ps
module fsku_checker #(
    parameter int HALF_BIT = 20000
) (
    input logic clk,
    input logic rst,
    input logic word_valid,
    input logic b0,
    input logic shift,
    input logic busy,
    input logic rdy_n,
    input logic sdata,
    input logic overrun
);
    localparam int LW = $clog2(HALF_BIT + 2) + 1;
    logic [LW-1:0] low_cycles;

    always_ff @(posedge clk) begin
        if (rst)             low_cycles <= '0;
        else if (word_valid) low_cycles <= LW'(1);
        else if (!rdy_n)     low_cycles <= low_cycles + 1'b1;
        else                 low_cycles <= '0;
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (rdy_n && sdata && !overrun));
    p_load_drops_ready_r2: assert property (@(posedge clk) disable iff (rst) word_valid |=> !rdy_n);
    p_load_shows_b0_r2: assert property (@(posedge clk) disable iff (rst) word_valid |=> (sdata == $past(b0)));
    p_edge_releases_ready_r3: assert property (@(posedge clk) disable iff (rst) (shift && !rdy_n) |=> rdy_n);
    p_ready_window_r4: assert property (@(posedge clk) disable iff (rst) !rdy_n |-> (low_cycles <= LW'(HALF_BIT)));
    p_overrun_set_r8: assert property (@(posedge clk) disable iff (rst) (word_valid && busy) |=> overrun);
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst) overrun |=> overrun);
endmodule

bind fsk_word_unloader fsku_checker #(.HALF_BIT(HALF_BIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .word_valid(word_valid),
    .b0        (word_data[0]),
    .shift     (shift),
    .busy      (busy),
    .rdy_n     (rdy_n),
    .sdata     (sdata),
    .overrun   (overrun)
);

// File: tb/fsk_word_unloader_test.sv
`timescale 1ns/1ps
module fsk_word_unloader_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       word_valid = 1'b0;
    logic [7:0] word_data = 8'h00;
    logic       word_stop = 1'b1;
    logic       host_clk = 1'b0;
    logic       rdy_n, sdata, overrun;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_word_unloader #(.HALF_BIT(HALF)) uut (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
        .word_stop(word_stop), .host_clk(host_clk),
        .rdy_n(rdy_n), .sdata(sdata), .overrun(overrun)
    );

    function automatic logic exp_bit(input logic [7:0] d, input logic s, input int n);
        if (n == 0)      return d[0];
        else if (n <= 8) return d[n-1];
        else if (n == 9) return s;
        else             return 1'b1;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [7:0] d, input logic s);
        @(negedge clk);
        word_data  = d;
        word_stop  = s;
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        host_clk = 1'b1;
        repeat (4) @(negedge clk);
        host_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       s;
        int         np;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 rdy_n", rdy_n, 1'b1);
        chk("R1 sdata", sdata, 1'b1);
        chk("R1 overrun", overrun, 1'b0);

        // R10: idle pulses do nothing
        pulse();
        pulse();
        chk("R10 sdata", sdata, 1'b1);
        chk("R10 rdy_n", rdy_n, 1'b1);

        // R4: timeout, then R5 edges after timeout
        d = 8'hA5; s = 1'b1;
        send_word(d, s);
        chk("R2 rdy_n low", rdy_n, 1'b0);
        chk("R2 b0", sdata, d[0]);
        repeat (HALF - 1) @(negedge clk);
        chk("R4 still low", rdy_n, 1'b0);
        @(negedge clk);
        chk("R4 released", rdy_n, 1'b1);
        for (int n = 1; n <= 8; n++) begin
            pulse();
            chk("R5 after timeout", sdata, exp_bit(d, s, n));
        end

        // Random words: R2, R3, R5, R6
        for (int w = 0; w < 16; w++) begin
            d  = 8'($urandom);
            s  = 1'($urandom);
            np = 8 + int'($urandom % 3);
            send_word(d, s);
            chk("R2 rdy_n low", rdy_n, 1'b0);
            chk("R2 b0", sdata, d[0]);
            for (int n = 1; n <= np; n++) begin
                pulse();
                if (n == 1) chk("R3 ready released", rdy_n, 1'b1);
                if (n <= 8)      chk("R5 data bit", sdata, exp_bit(d, s, n));
                else if (n == 9) chk("R6 stop bit", sdata, exp_bit(d, s, n));
                else             chk("R6 idle after stop", sdata, 1'b1);
            end
        end
        chk("R8 no false overrun", overrun, 1'b0);

        // R7: edge coinciding with load is discarded
        d = 8'b0000_0010; s = 1'b0;
        @(negedge clk);
        host_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        word_data = d; word_stop = s; word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 ready held", rdy_n, 1'b0);
        host_clk = 1'b0;
        repeat (3) @(negedge clk);
        pulse();
        chk("R7 first pulse b0", sdata, d[0]);
        chk("R7 ready released", rdy_n, 1'b1);
        for (int n = 2; n <= 9; n++) begin
            pulse();
            chk("R7 sequence", sdata, exp_bit(d, s, n));
        end

        // R9: host clock high across the ready fall
        d = 8'b0000_0001; s = 1'b1;
        @(negedge clk);
        host_clk = 1'b1;
        repeat (4) @(negedge clk);
        send_word(d, s);
        repeat (3) @(negedge clk);
        chk("R9 no shift rdy", rdy_n, 1'b0);
        chk("R9 no shift b0", sdata, d[0]);
        host_clk = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 fall alone", rdy_n, 1'b0);
        pulse();
        chk("R9 first fresh edge", sdata, d[0]);
        pulse();
        chk("R9 second edge", sdata, d[1]);
        for (int n = 3; n <= 8; n++) pulse();
        chk("R8 no overrun after 8", overrun, 1'b0);

        // R8: overrun
        send_word(8'h3C, 1'b1);
        pulse(); pulse(); pulse();
        d = 8'b1000_0001; s = 1'b0;
        send_word(d, s);
        chk("R8 overrun set", overrun, 1'b1);
        chk("R8 new b0", sdata, d[0]);
        chk("R8 rdy low", rdy_n, 1'b0);
        for (int n = 1; n <= 9; n++) begin
            pulse();
            chk("R8 new word bits", sdata, exp_bit(d, s, n));
        end
        send_word(8'h55, 1'b1);
        chk("R8 sticky", overrun, 1'b1);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule